// File: doc/BRIEF.md
# Transceiver Vendor Control Register with General-Purpose Pins

This block is a 16-bit control register inside an Ethernet transceiver. Its stored fields set the line behaviour: repeater operation, the active level of the interrupt pin, a transmit high-impedance state, suppression of the 10BASE-T SQE test and a 10BASE-T transmit-to-receive loopback. It also serves two general-purpose pins. Each pin has a direction bit and a data bit.

The management side reaches the register through a plain port. An address-match strobe gates both writes and read data, a write enable commits the write word, and a registered read word returns the register image. Decoding of management frames and the analog drivers sit outside the block. The block exports only registered control levels, the interrupt pin level and the pad controls for the general-purpose pins.

Top module: `phy_vendor_ctrl`

## Requirements
- R1: A synchronous active-high reset brings every field to its default. The read image is then 0x0140, because both direction bits (8 and 6) reset to 1. After reset the interrupt pin sits at 1, both pad output enables are 0, and the high-impedance output is 0.
- R2: A write with select and write enable high stores bit 15 (repeater), bit 14 (interrupt polarity), bit 11 (SQE inhibit), bit 10 (loopback) and the pin bits 9..6. A write enable without select changes nothing.
- R3: While bit 15 is 1, the full-duplex-allowed output is 0, the receive-only carrier output is 1 and the SQE test enable is 0. While bit 15 is 0, the full-duplex-allowed output is 1 and the receive-only carrier output is 0.
- R4: With bit 14 at 0 the interrupt pin is the inverse of the raw request. With bit 14 at 1 the pin follows the request. The pin registers the request one clock after it is sampled.
- R5: Writing 1 to bit 12 sets the transmit high-impedance output. Writing 0 to bit 12 leaves it set. Only reset clears it.
- R6: The SQE test enable is 1 only when 10BASE-T mode is active, bit 11 is 0 and bit 15 is 0.
- R7: The loopback enable is 1 only when bit 10 is 1 and 10BASE-T mode is active.
- R8: Bit 8 sets the direction of pin 1 and bit 6 sets the direction of pin 0. A direction bit of 1 makes the pin an input, with its output enable at 0. A direction bit of 0 drives the pin's data bit (9 for pin 1, 7 for pin 0) out with its output enable at 1.
- R9: For a pin set as input, its data bit reads the pin level after a two-flop synchronizer. It appears in read data on the third clock edge after the level is applied. For a pin set as output, its data bit reads the written value.
- R10: Bit 13 and bits 5..0 always read 0, whatever was written to them.
- R11: Read data is 0 one clock after a cycle in which select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register address match; gates writes and read data |
| wr_en | input | 1 | Write enable |
| wr_data | input | 16 | Write word |
| rd_data | output | 16 | Registered read word |
| irq_req | input | 1 | Raw interrupt request, active high |
| irq_pin | output | 1 | Interrupt pin level after polarity selection |
| mode_10bt | input | 1 | High while the link runs at 10BASE-T |
| repeater_mode | output | 1 | Repeater operation active |
| fdx_allowed | output | 1 | Full duplex may be advertised or used |
| crs_rx_only | output | 1 | Carrier sense follows receive activity only |
| sqe_test_en | output | 1 | Generate a collision pulse after each 10BASE-T transmission |
| tx_hiz | output | 1 | Transmit drivers and transmit clock in high impedance |
| loopback_en | output | 1 | Route 10BASE-T transmit data to receive data |
| gpio_in | input | 2 | Pad input levels, pin 1 in bit 1 |
| gpio_out | output | 2 | Pad output levels |
| gpio_oe | output | 2 | Pad output enables, 1 drives the pad |

## Verification
A write that meets a rising edge updates the fields on that edge. Read data and the control outputs follow one edge later. A change in irq_req or mode_10bt reaches its outputs on the next edge, and a pad level reaches read data on the third edge. Each table vector is applied at a falling edge and committed on one rising edge. The bench then waits three more rising edges, so every result has settled, and samples at a falling edge. Directed tests check the exact latencies: the interrupt pin is checked one edge after the request changes, and the pad input is checked both one edge before and on the edge it is due.

// File: rtl/phy_vctl_pkg.sv
package phy_vctl_pkg;
  localparam int REG_W     = 16;
  localparam int NUM_GPIO  = 2;

  // field positions decoded by the management side
  localparam int B_RPTR    = 15;
  localparam int B_IRQPOL  = 14;
  localparam int B_HIZ     = 12;
  localparam int B_SQEINH  = 11;
  localparam int B_LB10    = 10;
  localparam int B_GPIO_LO = 6;   // pin i: dir at LO+2i, data at LO+2i+1

  function automatic int dir_pos(input int i);
    return B_GPIO_LO + 2 * i;
  endfunction

  function automatic int dat_pos(input int i);
    return B_GPIO_LO + 2 * i + 1;
  endfunction

  typedef struct packed {
    logic                rptr;
    logic                irq_pol;
    logic                tx_hiz;
    logic                sqe_inh;
    logic                lb10;
    logic [NUM_GPIO-1:0] gdir;
    logic [NUM_GPIO-1:0] gdat;
  } vctl_fields_t;
endpackage

// File: rtl/vctl_sync.sv
module vctl_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/vctl_field_regs.sv
module vctl_field_regs
  import phy_vctl_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int NG     = NUM_GPIO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output vctl_fields_t      fields
);
  localparam vctl_fields_t RST_VAL = '{
    rptr: 1'b0, irq_pol: 1'b0, tx_hiz: 1'b0, sqe_inh: 1'b0, lb10: 1'b0,
    gdir: {NG{1'b1}}, gdat: '0
  };

  logic wr_hit;
  assign wr_hit = sel && wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      fields <= RST_VAL;
    end else if (wr_hit) begin
      fields.rptr    <= wr_data[B_RPTR];
      fields.irq_pol <= wr_data[B_IRQPOL];
      fields.sqe_inh <= wr_data[B_SQEINH];
      fields.lb10    <= wr_data[B_LB10];
      // sticky: a write can set it, only reset clears it
      fields.tx_hiz  <= fields.tx_hiz | wr_data[B_HIZ];
      for (int i = 0; i < NG; i++) begin
        fields.gdir[i] <= wr_data[dir_pos(i)];
        fields.gdat[i] <= wr_data[dat_pos(i)];
      end
    end
  end
endmodule

// File: rtl/vctl_gpio_pin.sv
module vctl_gpio_pin (
  input  logic clk,
  input  logic rst,
  input  logic dir_in,
  input  logic dat,
  input  logic pin_sync,
  output logic pad_oe,
  output logic pad_out,
  output logic rd_bit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= 1'b0;
      pad_out <= 1'b0;
    end else begin
      pad_oe  <= ~dir_in;
      pad_out <= dat;
    end
  end

  assign rd_bit = dir_in ? pin_sync : dat;
endmodule

// File: rtl/vctl_line_ctrl.sv
module vctl_line_ctrl
  import phy_vctl_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  vctl_fields_t fields,
  input  logic         mode_10bt,
  input  logic         irq_req,
  output logic         irq_pin,
  output logic         repeater_mode,
  output logic         fdx_allowed,
  output logic         crs_rx_only,
  output logic         sqe_test_en,
  output logic         tx_hiz,
  output logic         loopback_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pin       <= 1'b1;
      repeater_mode <= 1'b0;
      fdx_allowed   <= 1'b1;
      crs_rx_only   <= 1'b0;
      sqe_test_en   <= 1'b0;
      tx_hiz        <= 1'b0;
      loopback_en   <= 1'b0;
    end else begin
      irq_pin       <= irq_req ^ ~fields.irq_pol;
      repeater_mode <= fields.rptr;
      fdx_allowed   <= ~fields.rptr;
      crs_rx_only   <= fields.rptr;
      sqe_test_en   <= mode_10bt & ~fields.sqe_inh & ~fields.rptr;
      tx_hiz        <= fields.tx_hiz;
      loopback_en   <= fields.lb10 & mode_10bt;
    end
  end
endmodule

// File: rtl/phy_vendor_ctrl.sv
module phy_vendor_ctrl
  import phy_vctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  input  logic                irq_req,
  output logic                irq_pin,
  input  logic                mode_10bt,
  output logic                repeater_mode,
  output logic                fdx_allowed,
  output logic                crs_rx_only,
  output logic                sqe_test_en,
  output logic                tx_hiz,
  output logic                loopback_en,
  input  logic [NUM_GPIO-1:0] gpio_in,
  output logic [NUM_GPIO-1:0] gpio_out,
  output logic [NUM_GPIO-1:0] gpio_oe
);
  vctl_fields_t        fields;
  logic [NUM_GPIO-1:0] pin_sync;
  logic [NUM_GPIO-1:0] rd_bits;
  logic [REG_W-1:0]    image;

  vctl_field_regs #(.DATA_W(REG_W), .NG(NUM_GPIO)) u_regs (
    .clk, .rst, .sel, .wr_en, .wr_data, .fields
  );

  vctl_sync #(.W(NUM_GPIO), .STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst, .d(gpio_in), .q(pin_sync)
  );

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin
    vctl_gpio_pin u_pin (
      .clk, .rst,
      .dir_in  (fields.gdir[g]),
      .dat     (fields.gdat[g]),
      .pin_sync(pin_sync[g]),
      .pad_oe  (gpio_oe[g]),
      .pad_out (gpio_out[g]),
      .rd_bit  (rd_bits[g])
    );
  end

  vctl_line_ctrl u_line (
    .clk, .rst, .fields, .mode_10bt, .irq_req, .irq_pin,
    .repeater_mode, .fdx_allowed, .crs_rx_only, .sqe_test_en,
    .tx_hiz, .loopback_en
  );

  always_comb begin
    image           = '0;
    image[B_RPTR]   = fields.rptr;
    image[B_IRQPOL] = fields.irq_pol;
    image[B_HIZ]    = fields.tx_hiz;
    image[B_SQEINH] = fields.sqe_inh;
    image[B_LB10]   = fields.lb10;
    for (int i = 0; i < NUM_GPIO; i++) begin
      image[dir_pos(i)] = fields.gdir[i];
      image[dat_pos(i)] = rd_bits[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel ? image : '0;
  end
endmodule

// File: rtl/phy_vendor_ctrl_chk.sv
module phy_vendor_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        sel,
  input logic [15:0] rd_data,
  input logic        irq_req,
  input logic        irq_pin,
  input logic        pol,
  input logic        hiz_q,
  input logic        lb_q,
  input logic        mode_10bt,
  input logic        loopback_en,
  input logic [1:0]  dir_q,
  input logic [1:0]  gpio_oe,
  input logic        repeater_mode,
  input logic        fdx_allowed,
  input logic        crs_rx_only,
  input logic        sqe_test_en
);
  p_repeater_r3: assert property (@(posedge clk) disable iff (rst)
    repeater_mode |-> (!fdx_allowed && crs_rx_only && !sqe_test_en));

  p_irq_level_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> irq_pin == ($past(pol) ? $past(irq_req) : !$past(irq_req)));

  p_hiz_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    hiz_q |=> hiz_q);

  p_loopback_r7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> loopback_en == ($past(lb_q) && $past(mode_10bt)));

  p_pad_dir_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> gpio_oe == ~$past(dir_q));

  p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    rd_data[13] == 1'b0 && rd_data[5:0] == 6'd0);

  p_unselected_r11: assert property (@(posedge clk) disable iff (rst)
    !sel |=> rd_data == 16'd0);
endmodule

bind phy_vendor_ctrl phy_vendor_ctrl_chk u_chk (
  .clk, .rst, .sel, .rd_data, .irq_req, .irq_pin,
  .pol(fields.irq_pol), .hiz_q(fields.tx_hiz), .lb_q(fields.lb10),
  .mode_10bt, .loopback_en, .dir_q(fields.gdir), .gpio_oe,
  .repeater_mode, .fdx_allowed, .crs_rx_only, .sqe_test_en
);

// File: tb/phy_vendor_ctrl_test.sv
module phy_vendor_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, wr_en = 1'b0, irq_req = 1'b0, mode_10bt = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  gpio_in = '0;
  logic [15:0] rd_data;
  logic        irq_pin, repeater_mode, fdx_allowed, crs_rx_only;
  logic        sqe_test_en, tx_hiz, loopback_en;
  logic [1:0]  gpio_out, gpio_oe;

  always #2 clk = ~clk;   // 250 MHz

  phy_vendor_ctrl uut (
    .clk, .rst, .sel, .wr_en, .wr_data, .rd_data, .irq_req, .irq_pin,
    .mode_10bt, .repeater_mode, .fdx_allowed, .crs_rx_only, .sqe_test_en,
    .tx_hiz, .loopback_en, .gpio_in, .gpio_out, .gpio_oe
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // {wdata, mode_10bt, irq_req, gpio_in, exp_rd, exp_ctl}
  // exp_ctl = {rptr, fdx, crs, sqe, hiz, lb, irq_pin, oe1, oe0, out1, out0}
  localparam logic [46:0] VECS [0:5] = '{
    {16'h0140, 1'b1, 1'b0, 2'b00, 16'h0140, 11'b0_1_0_1_0_0_1_00_00},
    {16'h8140, 1'b1, 1'b1, 2'b11, 16'h83C0, 11'b1_0_1_0_0_0_0_00_00},
    {16'h4400, 1'b1, 1'b1, 2'b11, 16'h4400, 11'b0_1_0_1_0_1_1_11_00},
    {16'h1A80, 1'b0, 1'b0, 2'b00, 16'h1A80, 11'b0_1_0_0_1_0_1_11_11},
    {16'h2C3F, 1'b1, 1'b0, 2'b10, 16'h1C00, 11'b0_1_0_0_1_1_1_11_00},
    {16'h0100, 1'b1, 1'b1, 2'b10, 16'h1300, 11'b0_1_0_1_1_0_0_01_00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    sel = 1'b1; wr_en = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [10:0] ctl_now();
    return {repeater_mode, fdx_allowed, crs_rx_only, sqe_test_en, tx_hiz,
            loopback_en, irq_pin, gpio_oe, gpio_out};
  endfunction

  initial begin
    @(negedge clk);
    edges(3);
    rst = 1'b0; sel = 1'b1;
    edges(2);
    check("R1 reset read image", rd_data, 16'h0140);
    check("R1 reset irq pin", irq_pin, 1'b1);
    check("R1 reset pad oe", gpio_oe, 2'b00);
    check("R1 reset hiz", tx_hiz, 1'b0);

    // table: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < 6; v++) begin
      mode_10bt = VECS[v][30];
      irq_req   = VECS[v][29];
      gpio_in   = VECS[v][28:27];
      wr(VECS[v][46:31]);
      edges(3);
      check($sformatf("R2/R10 vector %0d read", v), rd_data, VECS[v][26:11]);
      check($sformatf("R3-R9 vector %0d controls", v), ctl_now(), VECS[v][10:0]);
    end

    // R11 and R2: unselected write ignored, read data zero
    sel = 1'b0; wr_en = 1'b1; wr_data = 16'hFFFF;
    edges(1);
    wr_en = 1'b0;
    edges(1);
    check("R11 unselected read zero", rd_data, 16'h0000);
    sel = 1'b1;
    edges(2);
    check("R2 unselected write ignored", rd_data, 16'h1300);

    // R9 synchronizer latency on pin 1 (input)
    gpio_in = 2'b00;
    edges(2);
    check("R9 pin not yet visible", rd_data[9], 1'b1);
    edges(1);
    check("R9 pin visible on third edge", rd_data[9], 1'b0);

    // R4 one-edge latency, polarity 0
    irq_req = 1'b0;
    edges(1);
    check("R4 idle pin high", irq_pin, 1'b1);
    irq_req = 1'b1;
    edges(1);
    check("R4 active low pin", irq_pin, 1'b0);

    // R7 loopback gated by mode
    mode_10bt = 1'b0;
    wr(16'h0540);
    edges(2);
    check("R7 loopback off outside 10BASE-T", loopback_en, 1'b0);
    mode_10bt = 1'b1;
    edges(1);
    check("R7 loopback on in 10BASE-T", loopback_en, 1'b1);

    // R5 only reset clears hiz
    check("R5 hiz still set", tx_hiz, 1'b1);
    rst = 1'b1;
    edges(1);
    rst = 1'b0;
    edges(2);
    check("R5 reset clears hiz", tx_hiz, 1'b0);
    check("R1 image after reset", rd_data, 16'h0140);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule